// File: doc/BRIEF.md
# Split-Control Gray Up/Down Counter

This block counts through the eight codes of a 3-bit reflected Gray sequence, forwards or backwards, one step per clock. Internally it is not one eight-state machine. It is two small controllers, and each one has four count positions and an idle position. The lower controller covers the codes whose top bit is 0 (000, 001, 011, 010). The upper controller covers the codes whose top bit is 1 (110, 111, 101, 100).

At any time exactly one controller is counting and the other waits in idle. When the count runs off the end of the running controller's half, in either direction, that controller raises a leave request and drops to idle. On the same clock edge the waiting controller sees the request and starts at the matching end of its own half. No code is skipped or repeated at the crossing.

The direction select is sampled on every clock edge and may change on any cycle. The output code is taken from whichever controller is running. A valid flag shows that exactly one controller holds the count.

Top module: `gray_split_counter`

## Requirements
- R1: While the synchronous reset is high at a rising edge, the next state is the lower controller running at code 000 with the upper controller idle. The port `cnt_gray` then reads 000 and `cnt_valid` reads 1.
- R2: With `up_dn`=1 at a rising edge, `cnt_gray` moves one step forward in the cycle 000, 001, 011, 010, 110, 111, 101, 100, 000.
- R3: With `up_dn`=0 at a rising edge, `cnt_gray` moves one step backward in the same cycle.
- R4: After reset, exactly one controller is running in every cycle, and `cnt_valid` stays 1.
- R5: Counting up from 010, the lower controller goes idle and the upper controller takes over at 110 on the same edge.
- R6: Counting up from 100, the upper controller goes idle and the lower controller takes over at 000 on the same edge.
- R7: Counting down from 000, control passes to the upper controller at 100 on the same edge.
- R8: Counting down from 110, control passes to the lower controller at 010 on the same edge.
- R9: Every clock edge without reset changes exactly one bit of `cnt_gray`.
- R10: The direction may reverse on the cycle right after a handoff. The count then steps straight back across the boundary, and control returns to the first controller.
- R11: A reset applied in the middle of a count returns the output to 000 at the next rising edge, whichever controller was running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| up_dn | input | 1 | 1 counts forward, 0 counts backward |
| cnt_gray | output | 3 | Current Gray code, taken from the running controller |
| cnt_valid | output | 1 | High when exactly one controller holds the count |

## Verification
A controller that enters at the wrong end of its half, or that misses a leave request, shows up at the ports on the very next edge. In the first case `cnt_gray` jumps by more than one bit. In the second case both controllers are idle or both are running, and `cnt_valid` drops. A wrong local position that stays inside one half stays hidden until the next crossing in that direction, which happens within four cycles when the direction is held. Because of this, the bench compares the output on every cycle against a flat reference counter, and it uses direction patterns that reverse right at the boundaries.

// File: rtl/gray_split_pkg.sv
package gray_split_pkg;
  // Working width for the shared code helpers; counters narrower than this
  // zero-extend on the way in and truncate on the way out.
  localparam int GW = 16;

  typedef enum logic {
    HS_IDLE = 1'b0,
    HS_RUN  = 1'b1
  } half_state_e;

  // Binary position to reflected Gray code.
  function automatic logic [GW-1:0] to_gray(input logic [GW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // Reflected Gray code back to binary position (prefix XOR from the top).
  function automatic logic [GW-1:0] to_bin(input logic [GW-1:0] g);
    logic [GW-1:0] r;
    r[GW-1] = g[GW-1];
    for (int i = GW - 2; i >= 0; i--) begin
      r[i] = r[i+1] ^ g[i];
    end
    return r;
  endfunction
endpackage

// File: rtl/gray_half_fsm.sv
module gray_half_fsm #(
  parameter int CNT_W        = 3,
  parameter bit START_ACTIVE = 1'b0,
  localparam int LOC_W       = CNT_W - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_up,
  input  logic             enter_low,
  input  logic             enter_high,
  output logic             run,
  output logic [LOC_W-1:0] loc_idx,
  output logic             leave_up,
  output logic             leave_down
);
  import gray_split_pkg::*;

  localparam logic [LOC_W-1:0] LOC_MAX = {LOC_W{1'b1}};
  localparam logic [LOC_W-1:0] LOC_ONE = LOC_W'(1);

  half_state_e st_q, st_d;
  logic [LOC_W-1:0] idx_q, idx_d;

  // Running off either end of this half hands the count to the peer.
  assign leave_up   = (st_q == HS_RUN) &&  dir_up && (idx_q == LOC_MAX);
  assign leave_down = (st_q == HS_RUN) && !dir_up && (idx_q == '0);

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    if (st_q == HS_RUN) begin
      if (leave_up || leave_down) begin
        st_d = HS_IDLE;
      end else if (dir_up) begin
        idx_d = idx_q + LOC_ONE;
      end else begin
        idx_d = idx_q - LOC_ONE;
      end
    end else if (enter_low) begin
      st_d  = HS_RUN;
      idx_d = '0;
    end else if (enter_high) begin
      st_d  = HS_RUN;
      idx_d = LOC_MAX;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= START_ACTIVE ? HS_RUN : HS_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign run     = (st_q == HS_RUN);
  assign loc_idx = idx_q;
endmodule

// File: rtl/gray_out_sel.sv
module gray_out_sel #(
  parameter int CNT_W  = 3,
  localparam int LOC_W = CNT_W - 1
) (
  input  logic             a_run,
  input  logic             b_run,
  input  logic [LOC_W-1:0] a_idx,
  input  logic [LOC_W-1:0] b_idx,
  output logic [CNT_W-1:0] cnt_gray,
  output logic             cnt_valid
);
  import gray_split_pkg::*;

  logic [CNT_W-1:0] pos_bin;

  // The half index is the top binary bit; the local index fills the rest.
  always_comb begin
    if (b_run) pos_bin = {1'b1, b_idx};
    else       pos_bin = {1'b0, a_idx};
    cnt_gray = CNT_W'(to_gray(GW'(pos_bin)));
  end

  assign cnt_valid = a_run ^ b_run;
endmodule

// File: rtl/gray_split_counter.sv
module gray_split_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_dn,
  output logic [CNT_W-1:0] cnt_gray,
  output logic             cnt_valid
);
  localparam int LOC_W = CNT_W - 1;

  logic             a_run, b_run;
  logic [LOC_W-1:0] a_idx, b_idx;
  logic             a_leave_up, a_leave_down;
  logic             b_leave_up, b_leave_down;

  // Lower half: starts running at reset.
  gray_half_fsm #(.CNT_W(CNT_W), .START_ACTIVE(1'b1)) u_lo (
    .clk       (clk),
    .rst       (rst),
    .dir_up    (up_dn),
    .enter_low (b_leave_up),
    .enter_high(b_leave_down),
    .run       (a_run),
    .loc_idx   (a_idx),
    .leave_up  (a_leave_up),
    .leave_down(a_leave_down)
  );

  // Upper half: idle at reset.
  gray_half_fsm #(.CNT_W(CNT_W), .START_ACTIVE(1'b0)) u_hi (
    .clk       (clk),
    .rst       (rst),
    .dir_up    (up_dn),
    .enter_low (a_leave_up),
    .enter_high(a_leave_down),
    .run       (b_run),
    .loc_idx   (b_idx),
    .leave_up  (b_leave_up),
    .leave_down(b_leave_down)
  );

  gray_out_sel #(.CNT_W(CNT_W)) u_sel (
    .a_run    (a_run),
    .b_run    (b_run),
    .a_idx    (a_idx),
    .b_idx    (b_idx),
    .cnt_gray (cnt_gray),
    .cnt_valid(cnt_valid)
  );
endmodule

// File: rtl/gray_split_counter_chk.sv
module gray_split_counter_chk #(
  parameter int CNT_W  = 3,
  localparam int LOC_W = CNT_W - 1
) (
  input logic             clk,
  input logic             rst,
  input logic             up_dn,
  input logic [CNT_W-1:0] cnt_gray,
  input logic             cnt_valid,
  input logic             a_run,
  input logic             b_run,
  input logic [LOC_W-1:0] a_idx,
  input logic [LOC_W-1:0] b_idx,
  input logic             a_leave_up,
  input logic             a_leave_down,
  input logic             b_leave_up,
  input logic             b_leave_down
);
  import gray_split_pkg::*;

  localparam logic [LOC_W-1:0] LOC_MAX = {LOC_W{1'b1}};

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (a_run && !b_run && cnt_gray == '0 && cnt_valid));

  // R4
  one_owner_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $onehot({a_run, b_run}) && cnt_valid);

  // R2
  step_up_chk: assert property (@(posedge clk) disable iff (rst)
    up_dn |=> CNT_W'(to_bin(GW'(cnt_gray))) ==
              CNT_W'(to_bin(GW'($past(cnt_gray))) + 1));

  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (rst)
    !up_dn |=> CNT_W'(to_bin(GW'(cnt_gray))) ==
               CNT_W'(to_bin(GW'($past(cnt_gray))) - 1));

  // R9
  one_bit_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $countones(cnt_gray ^ $past(cnt_gray)) == 1);

  // R5
  lo_to_hi_up_chk: assert property (@(posedge clk) disable iff (rst)
    a_leave_up |=> (b_run && !a_run && b_idx == '0));

  // R6
  hi_to_lo_up_chk: assert property (@(posedge clk) disable iff (rst)
    b_leave_up |=> (a_run && !b_run && a_idx == '0));

  // R7
  lo_to_hi_down_chk: assert property (@(posedge clk) disable iff (rst)
    a_leave_down |=> (b_run && !a_run && b_idx == LOC_MAX));

  // R8
  hi_to_lo_down_chk: assert property (@(posedge clk) disable iff (rst)
    b_leave_down |=> (a_run && !b_run && a_idx == LOC_MAX));
endmodule

bind gray_split_counter gray_split_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .up_dn       (up_dn),
  .cnt_gray    (cnt_gray),
  .cnt_valid   (cnt_valid),
  .a_run       (a_run),
  .b_run       (b_run),
  .a_idx       (a_idx),
  .b_idx       (b_idx),
  .a_leave_up  (a_leave_up),
  .a_leave_down(a_leave_down),
  .b_leave_up  (b_leave_up),
  .b_leave_down(b_leave_down)
);

// File: tb/gray_split_counter_test.sv
module gray_split_counter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       up_dn = 1'b1;
  logic [2:0] cnt_gray;
  logic       cnt_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 8 ns period, 125 MHz

  gray_split_counter #(.CNT_W(3)) uut (
    .clk      (clk),
    .rst      (rst),
    .up_dn    (up_dn),
    .cnt_gray (cnt_gray),
    .cnt_valid(cnt_valid)
  );

  // {direction, expected code after the edge}, starting from 000
  localparam int NVEC = 20;
  localparam logic [3:0] VEC [NVEC] = '{
    4'b1_001, 4'b1_011, 4'b1_010, 4'b1_110, 4'b1_111,
    4'b1_101, 4'b1_100, 4'b1_000, 4'b1_001, 4'b0_000,
    4'b0_100, 4'b0_101, 4'b1_100, 4'b0_101, 4'b0_111,
    4'b0_110, 4'b0_010, 4'b1_110, 4'b0_010, 4'b0_011
  };

  // Reference: a plain binary position turned into Gray bit by bit.
  function automatic logic [2:0] ref_gray(input logic [2:0] p);
    logic [2:0] g;
    g[2] = p[2];
    g[1] = p[2] ^ p[1];
    g[0] = p[1] ^ p[0];
    return g;
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_valid(input string req);
    checks++;
    if (cnt_valid !== 1'b1) begin
      errors++;
      $display("FAIL %s: actual valid %b expected 1", req, cnt_valid);
    end
  endtask

  task automatic step(input logic d, input logic [2:0] exp, input string req);
    up_dn = d;
    @(negedge clk);
    check(req, cnt_gray, exp);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] pos;
    logic [2:0] prev;

    // R1: reset state
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", cnt_gray, 3'b000);
    check_valid("R1");
    rst = 1'b0;

    // Table walk: R2 forward / R3 backward, boundaries inside (R5..R8, R10)
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][3], VEC[i][2:0], VEC[i][3] ? "R2" : "R3");
      check_valid("R4");
    end

    // Directed crossings
    do_reset();
    step(1'b1, 3'b001, "R2");
    step(1'b1, 3'b011, "R2");
    step(1'b1, 3'b010, "R2");
    step(1'b1, 3'b110, "R5");
    step(1'b0, 3'b010, "R10");   // reverse right after handoff
    step(1'b1, 3'b110, "R10");
    step(1'b1, 3'b111, "R2");
    step(1'b1, 3'b101, "R2");
    step(1'b1, 3'b100, "R2");
    step(1'b1, 3'b000, "R6");
    step(1'b0, 3'b100, "R10");
    step(1'b1, 3'b000, "R10");
    step(1'b0, 3'b100, "R7");
    step(1'b0, 3'b101, "R3");
    step(1'b0, 3'b111, "R3");
    step(1'b0, 3'b110, "R3");
    step(1'b0, 3'b010, "R8");
    check_valid("R4");

    // R11: reset while the upper half is running
    step(1'b1, 3'b110, "R5");
    step(1'b1, 3'b111, "R2");
    rst = 1'b1;
    @(negedge clk);
    check("R11", cnt_gray, 3'b000);
    check_valid("R11");
    rst = 1'b0;

    // Random direction run against the flat reference (R9 single-bit steps)
    pos = 3'b000;
    for (int n = 0; n < 3000; n++) begin
      logic d;
      d = 1'($urandom);
      if (n % 7 == 0) d = ~up_dn;   // force frequent reversals
      prev = cnt_gray;
      pos = d ? pos + 3'd1 : pos - 3'd1;
      step(d, ref_gray(pos), d ? "R2" : "R3");
      checks++;
      if ($countones(prev ^ cnt_gray) != 1) begin
        errors++;
        $display("FAIL R9: actual %b->%b expected one bit change", prev, cnt_gray);
      end
      check_valid("R4");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule